// File: doc/BRIEF.md
# Two-bank interleaved 2bpp bitmap scanout

This block turns a four-colour bitmap into a raster pixel stream. It runs a horizontal and vertical timing generator on the pixel clock and fetches packed bytes from two video RAM banks. Even scanlines come from bank 0 and odd scanlines from bank 1. Each bank has a synchronous read port: the bank returns the byte one clock after it sees the address. Each fetched byte unpacks into four 2-bit colour indices, most significant pair first. The indices leave the block together with a display-enable flag and horizontal and vertical sync.

Each bank keeps its own read offset. The offset advances by one per four-pixel group, and only on scanlines owned by that bank. Both offsets return to zero at every frame boundary. A status byte shows the blanking and vertical sync state to a host that polls it. The two light-pen bits in that byte are tied low. Palette lookup, the write path into the banks and any timing register file are outside the block. The default geometry is 320x200 active pixels in a 400x262 raster, which gives about 60 frames per second at a pixel clock near 6.3 MHz.

Top module: `lace_fb_scanout`

## Requirements
- R1: While reset is held, and for the first two clocks after it is released, disp_en, hsync, vsync and pix_idx are 0 and stat_byte is 0x01.
- R2: The position counter starts at pixel 0 of line 0 in the first clock after reset is released. Each line lasts H_ACT+H_FP+H_SW+H_BP clocks. All outputs show the position counted two clocks earlier. disp_en is 1 for pixels 0..H_ACT-1 of an active line.
- R3: A frame has V_ACT+V_FP+V_SW+V_BP lines. Only lines 0..V_ACT-1 carry disp_en.
- R4: hsync is 1 for pixel positions H_ACT+H_FP up to H_ACT+H_FP+H_SW-1. vsync is 1 for lines V_ACT+V_FP up to V_ACT+V_FP+V_SW-1. vsync never coincides with disp_en.
- R5: Active pixel h shows bits [7-2*(h mod 4) -: 2] of its byte, so bits 7:6 are the leftmost pixel of the group and bits 1:0 the rightmost.
- R6: On even-numbered lines the byte comes from bank 0. On odd-numbered lines it comes from bank 1.
- R7: The pixel at h on line l uses the byte at offset (l/2)*(H_ACT/4) + h/4 of its bank, read one clock after that address is driven. A bank's offset does not move on lines of the other bank.
- R8: Both bank offsets return to 0 at the frame boundary, so every frame repeats the same bytes at the same positions.
- R9: When disp_en is 0, pix_idx is 0.
- R10: In stat_byte, bit 0 is 1 whenever disp_en is 0. Bit 3 equals vsync. Bit 1 (light-pen trigger), bit 2 (light-pen switch) and bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank0_addr | output | ADDR_W | Read offset into the even-line bank |
| bank0_rdata | input | 8 | Byte from the even-line bank, one clock after its address |
| bank1_addr | output | ADDR_W | Read offset into the odd-line bank |
| bank1_rdata | input | 8 | Byte from the odd-line bank, one clock after its address |
| pix_idx | output | 2 | Colour index of the current pixel |
| disp_en | output | 1 | High inside the active area |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| stat_byte | output | 8 | Host-readable blanking and sync status |

## Verification
The assertions check a few things on every cycle. The horizontal counter wraps at the end of the line. An offset stays frozen while the other bank's line is fetching. Both offsets are cleared after the frame boundary, and vsync never overlaps disp_en. Other properties show up only at the ports over whole frames, so the bench's sweep has to show them: the two-clock output lag, the MSB-first unpacking order, the choice of bank by line parity, the exact byte offset for each pixel, and a repeat of the same image in later frames. The sweep uses a small raster with an odd number of active lines, so bank 0 owns one line more than bank 1.

// File: rtl/lace_pkg.sv
package lace_pkg;
   // status byte layout seen by the host
   localparam int ST_BLANK    = 0;
   localparam int ST_PEN_TRIG = 1;
   localparam int ST_PEN_SW   = 2;
   localparam int ST_VSYNC    = 3;
   // light-pen hardware is absent: both bits read as constants
   localparam logic PEN_TRIG_LVL = 1'b0;
   localparam logic PEN_SW_LVL   = 1'b0;

   typedef struct packed {
      logic de;
      logic hs;
      logic vs;
   } sync_t;
endpackage

// File: rtl/lace_timing.sv
module lace_timing #(
   parameter int H_ACT = 320,
   parameter int H_FP  = 8,
   parameter int H_SW  = 32,
   parameter int H_BP  = 40,
   parameter int V_ACT = 200,
   parameter int V_FP  = 12,
   parameter int V_SW  = 3,
   parameter int V_BP  = 47,
   localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
   localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
   localparam int HW    = $clog2(H_TOT + 1),
   localparam int VW    = $clog2(V_TOT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hc,
   output logic          line_odd,
   output logic          active,
   output logic          hs,
   output logic          vs,
   output logic          frame_end
);
   localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
   localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
   localparam logic [HW-1:0] HA_C   = HW'(H_ACT);
   localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
   localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SW);
   localparam logic [VW-1:0] VA_C   = VW'(V_ACT);
   localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
   localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SW);

   logic [VW-1:0] vc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hc <= '0;
         vc <= '0;
      end else if (hc == H_LAST) begin
         hc <= '0;
         vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
      end else begin
         hc <= hc + 1'b1;
      end
   end

   assign line_odd  = vc[0];
   assign active    = (hc < HA_C) && (vc < VA_C);
   assign hs        = (hc >= HS_BEG) && (hc < HS_END);
   assign vs        = (vc >= VS_BEG) && (vc < VS_END);
   assign frame_end = (hc == H_LAST) && (vc == V_LAST);

   AST_HC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (hc == H_LAST) |=> (hc == '0));   // R2
endmodule

// File: rtl/lace_fetch.sv
module lace_fetch #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        hc_lo,
   input  logic              line_odd,
   input  logic              active,
   input  logic              frame_end,
   output logic [ADDR_W-1:0] ofs0,
   output logic [ADDR_W-1:0] ofs1,
   input  logic [7:0]        rd0,
   input  logic [7:0]        rd1,
   output logic [1:0]        pix_top
);
   logic       fetch;
   logic       fetch_q;
   logic       odd_q;
   logic [7:0] sh;

   // one address per 4-pixel group, issued at the group's first pixel
   assign fetch = active && (hc_lo == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs0    <= '0;
         ofs1    <= '0;
         fetch_q <= 1'b0;
         odd_q   <= 1'b0;
         sh      <= '0;
      end else begin
         if (frame_end) begin
            ofs0 <= '0;
            ofs1 <= '0;
         end else if (fetch) begin
            if (line_odd) ofs1 <= ofs1 + 1'b1;
            else          ofs0 <= ofs0 + 1'b1;
         end
         fetch_q <= fetch;
         odd_q   <= line_odd;
         if (fetch_q) sh <= odd_q ? rd1 : rd0;
         else         sh <= {sh[5:0], 2'b00};
      end
   end

   assign pix_top = sh[7:6];

   AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && line_odd && !frame_end) |=> $stable(ofs0));   // R7
   AST_ODD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && !line_odd && !frame_end) |=> $stable(ofs1));  // R7
   AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (ofs0 == '0 && ofs1 == '0));              // R8
endmodule

// File: rtl/lace_pipe.sv
module lace_pipe #(
   parameter int W     = 3,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) dout <= '0;
            else        dout <= din;
         end
      end else begin : g_chain
         logic [DEPTH*W-1:0] stg;
         always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[(DEPTH-1)*W-1:0], din};
         end
         assign dout = stg[DEPTH*W-1 -: W];
      end
   endgenerate
endmodule

// File: rtl/lace_fb_scanout.sv
module lace_fb_scanout #(
   parameter int H_ACT  = 320,
   parameter int H_FP   = 8,
   parameter int H_SW   = 32,
   parameter int H_BP   = 40,
   parameter int V_ACT  = 200,
   parameter int V_FP   = 12,
   parameter int V_SW   = 3,
   parameter int V_BP   = 47,
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] bank0_addr,
   input  logic [7:0]        bank0_rdata,
   output logic [ADDR_W-1:0] bank1_addr,
   input  logic [7:0]        bank1_rdata,
   output logic [1:0]        pix_idx,
   output logic              disp_en,
   output logic              hsync,
   output logic              vsync,
   output logic [7:0]        stat_byte
);
   import lace_pkg::*;

   localparam int H_TOT     = H_ACT + H_FP + H_SW + H_BP;
   localparam int V_TOT     = V_ACT + V_FP + V_SW + V_BP;
   localparam int HW        = $clog2(H_TOT + 1);
   localparam int BANK_LINES = (V_ACT + 1) / 2;
   localparam int BANK_BYTES = (H_ACT / 4) * BANK_LINES;
   // bank read takes one clock, shifter load takes one more
   localparam int LAT       = 2;

   generate
      if (H_ACT < 4 || (H_ACT % 4) != 0) begin : g_bad_hact
         $error("H_ACT must be a positive multiple of 4");
      end
      if (H_SW < 1 || V_SW < 1 || V_ACT < 1) begin : g_bad_sync
         $error("sync widths and V_ACT must be at least 1");
      end
      if (BANK_BYTES > (1 << ADDR_W)) begin : g_bad_aw
         $error("ADDR_W too small for one bank of the active area");
      end
   endgenerate

   logic [HW-1:0] hc;
   logic          line_odd, active, hs, vs, frame_end;
   logic [1:0]    pix_top;
   sync_t         sync_in, sync_out;

   lace_timing #(
      .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
      .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
   ) timing_i (
      .clk(clk), .rst_n(rst_n), .hc(hc), .line_odd(line_odd),
      .active(active), .hs(hs), .vs(vs), .frame_end(frame_end)
   );

   lace_fetch #(.ADDR_W(ADDR_W)) fetch_i (
      .clk(clk), .rst_n(rst_n), .hc_lo(hc[1:0]), .line_odd(line_odd),
      .active(active), .frame_end(frame_end),
      .ofs0(bank0_addr), .ofs1(bank1_addr),
      .rd0(bank0_rdata), .rd1(bank1_rdata), .pix_top(pix_top)
   );

   assign sync_in = '{de: active, hs: hs, vs: vs};

   lace_pipe #(.W($bits(sync_t)), .DEPTH(LAT)) pipe_i (
      .clk(clk), .rst_n(rst_n), .din(sync_in), .dout(sync_out)
   );

   assign disp_en = sync_out.de;
   assign hsync   = sync_out.hs;
   assign vsync   = sync_out.vs;
   assign pix_idx = sync_out.de ? pix_top : 2'b00;

   always_comb begin
      stat_byte              = '0;
      stat_byte[ST_BLANK]    = ~sync_out.de;
      stat_byte[ST_PEN_TRIG] = PEN_TRIG_LVL;
      stat_byte[ST_PEN_SW]   = PEN_SW_LVL;
      stat_byte[ST_VSYNC]    = sync_out.vs;
   end

   AST_VS_NOT_DE: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> !disp_en);   // R4
endmodule

// File: tb/lace_fb_scanout_tb_top.sv
module lace_fb_scanout_tb_top;
   localparam int HA = 8, HFP = 2, HSW = 2, HBP = 2;
   localparam int VA = 5, VFP = 1, VSW = 1, VBP = 1;
   localparam int AW = 4;
   localparam int HT = HA + HFP + HSW + HBP;
   localparam int VT = VA + VFP + VSW + VBP;
   localparam int FR = HT * VT;
   localparam int NFRAMES = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] b0_addr, b1_addr;
   logic [7:0]    b0_d, b1_d;
   logic [1:0]    pix_idx;
   logic          disp_en, hsync, vsync;
   logic [7:0]    stat_byte;

   logic [7:0] m0 [1<<AW];
   logic [7:0] m1 [1<<AW];

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always_ff @(posedge clk) begin
      b0_d <= m0[b0_addr];
      b1_d <= m1[b1_addr];
   end

   lace_fb_scanout #(
      .H_ACT(HA), .H_FP(HFP), .H_SW(HSW), .H_BP(HBP),
      .V_ACT(VA), .V_FP(VFP), .V_SW(VSW), .V_BP(VBP), .ADDR_W(AW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bank0_addr(b0_addr), .bank0_rdata(b0_d),
      .bank1_addr(b1_addr), .bank1_rdata(b1_d),
      .pix_idx(pix_idx), .disp_en(disp_en), .hsync(hsync), .vsync(vsync),
      .stat_byte(stat_byte)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   // t = clocks since reset release; outputs show position t-2
   task automatic check_cycle(input int t);
      int p, h, l, fr, ofs;
      logic [7:0] b;
      logic e_de, e_hs, e_vs;
      int e_pix;
      if (t < 2) begin
         chk("R1 de", int'(disp_en), 0);
         chk("R1 hs", int'(hsync), 0);
         chk("R1 vs", int'(vsync), 0);
         chk("R1 pix", int'(pix_idx), 0);
         chk("R1 stat", int'(stat_byte), 8'h01);
         return;
      end
      p  = t - 2;
      fr = p / FR;
      h  = p % HT;
      l  = (p / HT) % VT;
      e_de = (h < HA) && (l < VA);
      e_hs = (h >= HA + HFP) && (h < HA + HFP + HSW);
      e_vs = (l >= VA + VFP) && (l < VA + VFP + VSW);
      e_pix = 0;
      if (e_de) begin
         ofs = (l / 2) * (HA / 4) + h / 4;
         b = (l % 2 == 1) ? m1[ofs] : m0[ofs];
         e_pix = int'((b >> (6 - 2 * (h % 4))) & 8'h03);
      end
      chk(l < VA ? "R2 de" : "R3 de", int'(disp_en), int'(e_de));
      chk("R4 hs", int'(hsync), int'(e_hs));
      chk("R4 vs", int'(vsync), int'(e_vs));
      if (!e_de)       chk("R9 pix", int'(pix_idx), 0);
      else if (fr > 0) chk("R5/R6/R7/R8 pix", int'(pix_idx), e_pix);
      else             chk("R5/R6/R7 pix", int'(pix_idx), e_pix);
      chk("R10 stat", int'(stat_byte), int'({4'b0, e_vs, 1'b0, 1'b0, ~e_de}));
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         m0[i] = 8'(i * 37 + 5);
         m1[i] = 8'(i * 53 + 156);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 while reset is held
      chk("R1 rst de", int'(disp_en), 0);
      chk("R1 rst stat", int'(stat_byte), 8'h01);
      rst_n = 1'b1;
      check_cycle(0);
      for (int t = 1; t <= 2 + NFRAMES * FR; t++) begin
         @(negedge clk);
         check_cycle(t);
      end
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule